// File: doc/BRIEF.md
# Three-Stage Pipelined Two's-Complement Negator

This block returns the two's-complement negation of a 64-bit signed word, exactly three clock cycles after the word is presented with its valid flag. The work is split across three register stages. The first stage captures the word. The second stage flips every bit. The third stage adds one. There is no stall path, so a new word may be presented on every cycle. The valid flag moves through a matching three-deep chain, and that chain is the only state that reset clears.

A build-time parameter selects how the 64-bit word is read. In one mode it is a single 64-bit integer. In the other it holds two independent 32-bit signed integers, and each of these is negated on its own. In that second mode the increment is split at bit 32, so no carry passes from the lower half into the upper half. Data registers load only when their stage holds a valid word. The output word is defined only while the output valid flag is high.

Top module: `neg3_pipe`

## Requirements
- R1: `out_vld` equals the value `in_vld` had three rising clock edges earlier; the latency is fixed at three cycles.
- R2: Words presented on consecutive cycles with no gap all appear on consecutive output cycles, in order and without loss.
- R3: With `PACKED=0`, `out_word` equals (0 - w) mod 2^64, where w is the word presented three cycles earlier.
- R4: With `PACKED=1`, `out_word[31:0]` equals (0 - w[31:0]) mod 2^32 and `out_word[63:32]` equals (0 - w[63:32]) mod 2^32. No carry from the lower lane reaches the upper lane: for example, w = 0x00000005_00000000 gives 0xFFFFFFFB_00000000.
- R5: The most negative value maps to itself. 0x8000000000000000 returns unchanged when `PACKED=0`, and a lane of 0x80000000 returns unchanged when `PACKED=1`. No flag is raised.
- R6: While `rst_n` is low and after it is released, `out_vld` stays 0 until a valid word has completed the pipeline.
- R7: A cycle with `in_vld` low changes no data register, so `out_word` keeps the last valid result while bubbles pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid chain |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 64 | Signed input word, or two packed 32-bit lanes |
| out_vld | output | 1 | Output word is valid this cycle |
| out_word | output | 64 | Negated result, three cycles after input |

## Verification
The bound checker tests four things on every cycle once three edges have passed since reset. It checks the three-cycle alignment of the valid flag. It compares the output against the negation of the input three cycles earlier, lane by lane in packed mode. It confirms that the output holds steady behind a bubble, and that reset forces the output valid flag low. Several behaviours are shown only by the bench's directed scenarios, which run one instance in each mode side by side. These are the specific wrap-around values: zero, minus one, the most negative value, and a lower lane of zero next to a nonzero upper lane. The bench also covers unbroken bursts and the idle state held right after reset.

// File: rtl/neg3_pipe.sv
module neg3_pipe #(
  parameter int W      = 64,
  parameter bit PACKED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_word,
  output logic         out_vld,
  output logic [W-1:0] out_word
);
  localparam int LANES = PACKED ? 2 : 1;
  localparam int LW    = W / LANES;

  logic [2:0]   vld_q;
  logic [W-1:0] cap_q, inv_q, neg_q;
  logic [W-1:0] inc_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[1:0], in_vld};

  always_ff @(posedge clk) begin
    if (in_vld)   cap_q <= in_word;
    if (vld_q[0]) inv_q <= ~cap_q;
    if (vld_q[1]) neg_q <= inc_w;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign inc_w[g*LW +: LW] = inv_q[g*LW +: LW] + {{(LW-1){1'b0}}, 1'b1};
  end

  assign out_vld  = vld_q[2];
  assign out_word = neg_q;
endmodule

// File: rtl/neg3_pipe_chk.sv
module neg3_pipe_chk #(
  parameter int W      = 64,
  parameter bit PACKED = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic [W-1:0] in_word,
  input logic         out_vld,
  input logic [W-1:0] out_word
);
  localparam int H = W / 2;

  logic [1:0] age;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (out_vld) seen <= 1'b1;
    end

  function automatic logic [W-1:0] ref_neg(input logic [W-1:0] w);
    logic [H-1:0] lo, hi;
    lo = H'(0) - w[H-1:0];
    hi = H'(0) - w[W-1:H];
    return PACKED ? {hi, lo} : (W'(0) - w);
  endfunction

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R1

  AST_NEG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_vld) |-> (out_word == ref_neg($past(in_word, 3)))); // R3

  AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && seen && !$past(in_vld, 3)) |-> $stable(out_word)); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_vld); // R6
endmodule

bind neg3_pipe neg3_pipe_chk #(.W(W), .PACKED(PACKED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
  .out_vld(out_vld), .out_word(out_word)
);

// File: tb/tb_neg3_pipe.sv
module tb_neg3_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] in_word = '0;
  logic        f_vld, p_vld;
  logic [63:0] f_word, p_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        h_v [3];
  logic [63:0] h_w [3];
  bit          f_seen = 0, p_seen = 0;
  logic [63:0] f_last, p_last;

  always #10 clk = ~clk;

  neg3_pipe #(.W(64), .PACKED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .out_vld(f_vld), .out_word(f_word));

  neg3_pipe #(.W(64), .PACKED(1'b1)) dut_pk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .out_vld(p_vld), .out_word(p_word));

  function automatic logic [63:0] exp_full(input logic [63:0] w);
    return 64'd0 - w;
  endfunction

  function automatic logic [63:0] exp_pk(input logic [63:0] w);
    logic [31:0] lo, hi;
    lo = 32'd0 - w[31:0];
    hi = 32'd0 - w[63:32];
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [63:0] w, input string req);
    in_vld  = v;
    in_word = w;
    @(negedge clk);
    h_v[2] = h_v[1]; h_w[2] = h_w[1];
    h_v[1] = h_v[0]; h_w[1] = h_w[0];
    h_v[0] = v;      h_w[0] = w;
    chk({req, "/R1 valid"}, {63'd0, f_vld}, {63'd0, h_v[2]});
    chk({req, "/R1 valid pk"}, {63'd0, p_vld}, {63'd0, h_v[2]});
    if (h_v[2]) begin
      f_last = exp_full(h_w[2]);
      p_last = exp_pk(h_w[2]);
      f_seen = 1; p_seen = 1;
      chk({req, "/R3 full"}, f_word, f_last);
      chk({req, "/R4 packed"}, p_word, p_last);
    end else if (f_seen) begin
      chk({req, "/R7 hold"}, f_word, f_last);
      chk({req, "/R7 hold pk"}, p_word, p_last);
    end
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 3; i++) cyc(1'b0, 64'd0, req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) h_v[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 in reset", {63'd0, f_vld}, 64'd0);
    chk("R6 in reset pk", {63'd0, p_vld}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 64'hDEAD_BEEF_0000_1111, "R6 idle");
  endtask

  task automatic t_single;
    cyc(1'b1, 64'd1, "R3 one");
    flush("R3 one");
    cyc(1'b1, 64'h0000_0007_0000_0003, "R4 lanes");
    flush("R4 lanes");
    cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFF6, "R3 negative");
    flush("R3 negative");
  endtask

  task automatic t_corner;
    cyc(1'b1, 64'h8000_0000_0000_0000, "R5 min full");
    flush("R5 min full");
    chk("R5 full min kept", f_word, 64'h8000_0000_0000_0000);
    cyc(1'b1, 64'h8000_0000_8000_0000, "R5 min lanes");
    flush("R5 min lanes");
    chk("R5 packed min kept", p_word, 64'h8000_0000_8000_0000);
    cyc(1'b1, 64'h0000_0005_0000_0000, "R4 no carry");
    flush("R4 no carry");
    chk("R4 carry blocked", p_word, 64'hFFFF_FFFB_0000_0000);
    chk("R3 carry crosses", f_word, 64'hFFFF_FFFB_0000_0000);
    cyc(1'b1, 64'd0, "R3 zero");
    cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R3 minus one");
    flush("R3 minus one");
    chk("R3 minus one result", f_word, 64'd1);
    chk("R4 minus one lanes", p_word, 64'h0000_0001_0000_0001);
  endtask

  task automatic t_burst;
    logic [63:0] w = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, w, "R2 burst");
      w = {w[62:0], w[63] ^ w[61]} + 64'h9E37_79B9;
    end
    flush("R2 burst");
  endtask

  task automatic t_bubbles;
    cyc(1'b1, 64'h0000_0000_0000_0042, "R7 a");
    cyc(1'b0, 64'h5555_5555_5555_5555, "R7 bubble");
    cyc(1'b1, 64'h1111_1111_2222_2222, "R7 b");
    cyc(1'b0, 64'hAAAA_AAAA_AAAA_AAAA, "R7 bubble");
    cyc(1'b0, 64'h7777_7777_7777_7777, "R7 bubble");
    flush("R7 tail");
    for (int i = 0; i < 4; i++) cyc(1'b0, 64'hFFFF_0000_FFFF_0000, "R7 idle");
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_corner();
    t_burst();
    t_bubbles();
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule